// File: doc/BRIEF.md
# Ordered Memory Operation Queue with Store Forwarding

This block keeps the loads and stores of an out-of-order core in program order inside one circular queue. Each slot records whether it is a load or a store, the instruction's PC, its sequence number, a full word address, a data value, and progress flags. The progress flags are address known, data known, executed, done and faulted. The core allocates a slot at rename, fills in addresses and store data as they are computed, and then asks the queue to issue a load.

A load is never issued past an older store whose address is still unknown. When every older store has an address, the queue compares the load's address against all older stores at once and picks the youngest match. If that store already has its data, the load takes the data from it. If the data is still missing, the load is told to wait. If no older store matches, the queue sends a read to the data cache, and the returning fill completes the load. Stores write the cache only when they retire from the head of the queue. A flush carrying a sequence number discards every slot younger than that number.

Top module: `ldst_queue`

## Requirements
- R1: After reset the queue is empty (`head_valid`=0), `alloc_ready`=1, and `ld_resp_valid`, `cache_rd_valid` and `cache_wr_valid` are 0.
- R2: An allocation takes the slot shown on `alloc_idx`, and slots are handed out in ring order. Once DEPTH slots are held, `alloc_ready` is 0 and a further allocation request is ignored.
- R3: A load request is answered one cycle later on `ld_resp_valid`/`ld_resp_idx`. The code is 0 (wait-address) if the load itself, or any store older than it in the queue, has no known address.
- R4: If the youngest older store whose full address equals the load's address has known data, the code is 2 (forwarded) and `ld_resp_data` carries that store's data.
- R5: If that youngest matching older store has no data yet, the code is 1 (wait-data) and no cache read is issued.
- R6: If no older store matches, the code is 3 (cache). In the same cycle `cache_rd_valid` is 1, with the load's address on `cache_rd_addr` and its slot index on `cache_rd_tag`. `cache_rd_valid` is 1 in no other case.
- R7: Stores younger than the load take no part in the search, even when they match with data known.
- R8: A cache fill for a slot writes the value and marks the slot done. Both are visible on the head outputs when that slot is at the head.
- R9: A retire pops the head slot. A retired store produces exactly one cycle-later `cache_wr_valid` with its address and data, in queue order. A retired load writes nothing.
- R10: A flush removes every slot whose sequence number is younger than `flush_seq`, using modulo-2^SEQW comparison. An allocation in the flush cycle is ignored, and the next allocation follows the last kept slot.
- R11: A fault reported on the update port sets the slot's faulted flag, which is visible at the head.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | Allocate a slot at the tail |
| alloc_is_store | input | 1 | 1 = store, 0 = load |
| alloc_pc | input | PCW | PC of the operation |
| alloc_seq | input | SEQW | Sequence number of the operation |
| alloc_ready | output | 1 | A slot is free |
| alloc_idx | output | IW | Slot the next allocation takes |
| upd_valid | input | 1 | Update strobe |
| upd_idx | input | IW | Slot to update |
| upd_addr_valid | input | 1 | Write the address |
| upd_addr | input | AW | Word address |
| upd_data_valid | input | 1 | Write store data |
| upd_data | input | DW | Store data |
| upd_fault | input | 1 | Mark the slot faulted |
| ld_req_valid | input | 1 | Issue request for a load |
| ld_req_idx | input | IW | Slot of the load |
| ld_resp_valid | output | 1 | Load decision valid |
| ld_resp_idx | output | IW | Slot of the answered load |
| ld_resp_code | output | 2 | 0 wait-address, 1 wait-data, 2 forwarded, 3 cache |
| ld_resp_data | output | DW | Forwarded data (code 2) |
| cache_rd_valid | output | 1 | Cache read request |
| cache_rd_addr | output | AW | Read address |
| cache_rd_tag | output | IW | Slot tag returned with the fill |
| cache_fill_valid | input | 1 | Cache fill strobe |
| cache_fill_tag | input | IW | Slot being filled |
| cache_fill_data | input | DW | Fill data |
| retire_valid | input | 1 | Pop the head slot |
| cache_wr_valid | output | 1 | Cache write of a retired store |
| cache_wr_addr | output | AW | Write address |
| cache_wr_data | output | DW | Write data |
| flush_valid | input | 1 | Flush strobe |
| flush_seq | input | SEQW | Slots younger than this are removed |
| head_valid | output | 1 | Queue not empty |
| head_is_store | output | 1 | Head slot is a store |
| head_exec | output | 1 | Head slot executed |
| head_done | output | 1 | Head slot done |
| head_fault | output | 1 | Head slot faulted |
| head_seq | output | SEQW | Head sequence number |
| head_pc | output | PCW | Head PC |
| head_value | output | DW | Head value |

## Verification
The assertions rely on the environment to keep some rules. A retire is never asked for on an empty queue, and a retire never coincides with a flush. Updates, load requests and fills name only live slots. Sequence numbers rise by one per allocation, and the live spread stays far below 2^(SEQW-1). The stimulus follows these rules by construction. It allocates through a sequence counter, touches only the slot indices it has just allocated, retires only slots it has counted, and issues flushes on cycles that carry no retire. The sweep covers every combination of three older stores: address unknown, matching or differing in one bit, each with or without data. A matching younger store is always present behind the load, and the head sits at a wrapped position.

// File: rtl/ldst_pkg.sv
package ldst_pkg;
  typedef enum logic [1:0] {
    LDC_WAIT_ADDR = 2'd0,
    LDC_WAIT_DATA = 2'd1,
    LDC_FWD       = 2'd2,
    LDC_CACHE     = 2'd3
  } ld_code_e;
endpackage

// File: rtl/ldst_ptrs.sv
module ldst_ptrs #(
  parameter int DEPTH = 8,
  localparam int IW = $clog2(DEPTH),
  localparam int CW = IW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  input  logic          flush,
  input  logic [CW-1:0] kept,
  output logic [IW-1:0] head,
  output logic [IW-1:0] tail,
  output logic [CW-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else if (flush) begin
      count <= kept;
      tail  <= head + IW'(kept);
    end else begin
      head  <= head + IW'(pop);
      tail  <= tail + IW'(push);
      count <= count + CW'(push) - CW'(pop);
    end
  end

  p_count_bound_r2: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));

  p_count_step_r2: assert property (@(posedge clk) disable iff (rst)
    !$past(flush) |-> (count == $past(count) || count == $past(count) + 1'b1 ||
                       count + 1'b1 == $past(count)));

  p_flush_shrinks_r10: assert property (@(posedge clk) disable iff (rst)
    $past(flush) |-> (count <= $past(count) && $stable(head)));
endmodule

// File: rtl/ldst_age_search.sv
module ldst_age_search #(
  parameter int DEPTH = 8,
  parameter int AW = 16,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic [IW-1:0]             head,
  input  logic [IW-1:0]             ld_idx,
  input  logic [DEPTH-1:0]          is_store,
  input  logic [DEPTH-1:0]          addr_ok,
  input  logic [DEPTH-1:0]          data_ok,
  input  logic [DEPTH-1:0][AW-1:0]  addr,
  output logic                      blocked,
  output logic                      hit,
  output logic                      hit_data_ok,
  output logic [IW-1:0]             hit_idx
);
  logic [IW-1:0] ld_rank;
  logic [IW-1:0] slot;
  logic [AW-1:0] ld_addr;

  assign ld_rank = ld_idx - head;
  assign ld_addr = addr[ld_idx];

  // Walk from oldest to youngest; a later match overwrites, so the youngest
  // older matching store wins.
  always_comb begin
    blocked     = !addr_ok[ld_idx];
    hit         = 1'b0;
    hit_data_ok = 1'b0;
    hit_idx     = '0;
    slot        = '0;
    for (int r = 0; r < DEPTH; r++) begin
      slot = head + IW'(r);
      if (r < int'(ld_rank) && is_store[slot]) begin
        if (!addr_ok[slot]) begin
          blocked = 1'b1;
        end else if (addr[slot] == ld_addr) begin
          hit         = 1'b1;
          hit_data_ok = data_ok[slot];
          hit_idx     = slot;
        end
      end
    end
  end
endmodule

// File: rtl/ldst_queue.sv
module ldst_queue
  import ldst_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int PCW = 16,
  parameter int SEQW = 8,
  localparam int IW = $clog2(DEPTH),
  localparam int CW = IW + 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            alloc_valid,
  input  logic            alloc_is_store,
  input  logic [PCW-1:0]  alloc_pc,
  input  logic [SEQW-1:0] alloc_seq,
  output logic            alloc_ready,
  output logic [IW-1:0]   alloc_idx,
  input  logic            upd_valid,
  input  logic [IW-1:0]   upd_idx,
  input  logic            upd_addr_valid,
  input  logic [AW-1:0]   upd_addr,
  input  logic            upd_data_valid,
  input  logic [DW-1:0]   upd_data,
  input  logic            upd_fault,
  input  logic            ld_req_valid,
  input  logic [IW-1:0]   ld_req_idx,
  output logic            ld_resp_valid,
  output logic [IW-1:0]   ld_resp_idx,
  output logic [1:0]      ld_resp_code,
  output logic [DW-1:0]   ld_resp_data,
  output logic            cache_rd_valid,
  output logic [AW-1:0]   cache_rd_addr,
  output logic [IW-1:0]   cache_rd_tag,
  input  logic            cache_fill_valid,
  input  logic [IW-1:0]   cache_fill_tag,
  input  logic [DW-1:0]   cache_fill_data,
  input  logic            retire_valid,
  output logic            cache_wr_valid,
  output logic [AW-1:0]   cache_wr_addr,
  output logic [DW-1:0]   cache_wr_data,
  input  logic            flush_valid,
  input  logic [SEQW-1:0] flush_seq,
  output logic            head_valid,
  output logic            head_is_store,
  output logic            head_exec,
  output logic            head_done,
  output logic            head_fault,
  output logic [SEQW-1:0] head_seq,
  output logic [PCW-1:0]  head_pc,
  output logic [DW-1:0]   head_value
);
  // Slot storage (flops: every address feeds the parallel compare)
  logic [DEPTH-1:0]            e_store, e_aok, e_dok, e_exec, e_done, e_fault;
  logic [DEPTH-1:0][AW-1:0]    e_addr;
  logic [DEPTH-1:0][DW-1:0]    e_val;
  logic [DEPTH-1:0][PCW-1:0]   e_pc;
  logic [DEPTH-1:0][SEQW-1:0]  e_seq;

  logic [IW-1:0] head, tail;
  logic [CW-1:0] count, kept;
  logic [DEPTH-1:0] in_q, younger;

  logic alloc_fire, retire_fire, ld_fire;
  logic s_blocked, s_hit, s_hit_dok;
  logic [IW-1:0] s_hit_idx;
  ld_code_e ld_code;

  assign alloc_ready = (count != CW'(DEPTH));
  assign alloc_idx   = tail;
  assign alloc_fire  = alloc_valid && alloc_ready && !flush_valid;
  assign retire_fire = retire_valid && (count != '0) && !flush_valid;
  assign ld_fire     = ld_req_valid && !flush_valid;

  // Liveness and flush age per slot
  for (genvar i = 0; i < DEPTH; i++) begin : g_age
    logic [IW-1:0]   rank;
    logic [SEQW-1:0] dseq;
    assign rank       = IW'(i) - head;
    assign in_q[i]    = CW'(rank) < count;
    assign dseq       = e_seq[i] - flush_seq;
    assign younger[i] = in_q[i] && !dseq[SEQW-1] && (dseq != '0);
  end

  assign kept = count - CW'($countones(younger));

  ldst_ptrs #(.DEPTH(DEPTH)) ptrs_i (
    .clk   (clk),
    .rst   (rst),
    .push  (alloc_fire),
    .pop   (retire_fire),
    .flush (flush_valid),
    .kept  (kept),
    .head  (head),
    .tail  (tail),
    .count (count)
  );

  ldst_age_search #(.DEPTH(DEPTH), .AW(AW)) search_i (
    .head        (head),
    .ld_idx      (ld_req_idx),
    .is_store    (e_store),
    .addr_ok     (e_aok),
    .data_ok     (e_dok),
    .addr        (e_addr),
    .blocked     (s_blocked),
    .hit         (s_hit),
    .hit_data_ok (s_hit_dok),
    .hit_idx     (s_hit_idx)
  );

  always_comb begin
    if (s_blocked)       ld_code = LDC_WAIT_ADDR;
    else if (!s_hit)     ld_code = LDC_CACHE;
    else if (!s_hit_dok) ld_code = LDC_WAIT_DATA;
    else                 ld_code = LDC_FWD;
  end

  // Response, cache request and retire outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      ld_resp_valid  <= 1'b0;
      ld_resp_idx    <= '0;
      ld_resp_code   <= '0;
      ld_resp_data   <= '0;
      cache_rd_valid <= 1'b0;
      cache_rd_addr  <= '0;
      cache_rd_tag   <= '0;
      cache_wr_valid <= 1'b0;
      cache_wr_addr  <= '0;
      cache_wr_data  <= '0;
    end else begin
      ld_resp_valid  <= ld_fire;
      ld_resp_idx    <= ld_req_idx;
      ld_resp_code   <= ld_code;
      ld_resp_data   <= (ld_code == LDC_FWD) ? e_val[s_hit_idx] : '0;
      cache_rd_valid <= ld_fire && (ld_code == LDC_CACHE);
      cache_rd_addr  <= e_addr[ld_req_idx];
      cache_rd_tag   <= ld_req_idx;
      cache_wr_valid <= retire_fire && e_store[head];
      cache_wr_addr  <= e_addr[head];
      cache_wr_data  <= e_val[head];
    end
  end

  // Slot updates
  always_ff @(posedge clk) begin
    if (rst) begin
      e_store <= '0;
      e_aok   <= '0;
      e_dok   <= '0;
      e_exec  <= '0;
      e_done  <= '0;
      e_fault <= '0;
      e_addr  <= '0;
      e_val   <= '0;
      e_pc    <= '0;
      e_seq   <= '0;
    end else begin
      if (alloc_fire) begin
        e_store[tail] <= alloc_is_store;
        e_pc[tail]    <= alloc_pc;
        e_seq[tail]   <= alloc_seq;
        e_aok[tail]   <= 1'b0;
        e_dok[tail]   <= 1'b0;
        e_exec[tail]  <= 1'b0;
        e_done[tail]  <= 1'b0;
        e_fault[tail] <= 1'b0;
      end
      if (upd_valid) begin
        if (upd_addr_valid) begin
          e_addr[upd_idx] <= upd_addr;
          e_aok[upd_idx]  <= 1'b1;
          if (e_store[upd_idx]) e_exec[upd_idx] <= 1'b1;
        end
        if (upd_data_valid) begin
          e_val[upd_idx] <= upd_data;
          e_dok[upd_idx] <= 1'b1;
        end
        if (upd_fault) e_fault[upd_idx] <= 1'b1;
        if (e_store[upd_idx])
          e_done[upd_idx] <= (e_aok[upd_idx] | upd_addr_valid) &
                             (e_dok[upd_idx] | upd_data_valid);
      end
      if (ld_fire && ld_code == LDC_FWD) begin
        e_val[ld_req_idx]  <= e_val[s_hit_idx];
        e_exec[ld_req_idx] <= 1'b1;
        e_done[ld_req_idx] <= 1'b1;
      end else if (ld_fire && ld_code == LDC_CACHE) begin
        e_exec[ld_req_idx] <= 1'b1;
      end
      if (cache_fill_valid) begin
        e_val[cache_fill_tag]  <= cache_fill_data;
        e_done[cache_fill_tag] <= 1'b1;
      end
    end
  end

  assign head_valid    = (count != '0);
  assign head_is_store = e_store[head];
  assign head_exec     = e_exec[head];
  assign head_done     = e_done[head];
  assign head_fault    = e_fault[head];
  assign head_seq      = e_seq[head];
  assign head_pc       = e_pc[head];
  assign head_value    = e_val[head];

  // Assertions
  p_resp_after_req_r3: assert property (@(posedge clk) disable iff (rst)
    ld_resp_valid |-> $past(ld_req_valid));

  p_rd_only_cache_r6: assert property (@(posedge clk) disable iff (rst)
    cache_rd_valid |-> (ld_resp_valid && ld_resp_code == 2'd3 && cache_rd_tag == ld_resp_idx));

  p_fwd_from_live_store_r4: assert property (@(posedge clk) disable iff (rst)
    (ld_fire && s_hit && !s_blocked) |-> (e_store[s_hit_idx] && e_aok[s_hit_idx] && in_q[s_hit_idx]));

  p_fwd_older_r7: assert property (@(posedge clk) disable iff (rst)
    (ld_fire && s_hit) |-> ((s_hit_idx - head) < (ld_req_idx - head)));

  p_wr_after_retire_r9: assert property (@(posedge clk) disable iff (rst)
    cache_wr_valid |-> $past(retire_valid));

  p_retire_nonempty_r9: assert property (@(posedge clk) disable iff (rst)
    retire_valid |-> head_valid);

  p_no_retire_in_flush_r10: assert property (@(posedge clk) disable iff (rst)
    !(retire_valid && flush_valid));
endmodule

// File: tb/ldst_queue_tb.sv
module ldst_queue_tb_top;
  localparam int DEPTH = 8;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam int PCW = 16;
  localparam int SEQW = 8;
  localparam int IW = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic            alloc_valid = 0, alloc_is_store = 0;
  logic [PCW-1:0]  alloc_pc = '0;
  logic [SEQW-1:0] alloc_seq = '0;
  logic            alloc_ready;
  logic [IW-1:0]   alloc_idx;
  logic            upd_valid = 0, upd_addr_valid = 0, upd_data_valid = 0, upd_fault = 0;
  logic [IW-1:0]   upd_idx = '0;
  logic [AW-1:0]   upd_addr = '0;
  logic [DW-1:0]   upd_data = '0;
  logic            ld_req_valid = 0;
  logic [IW-1:0]   ld_req_idx = '0;
  logic            ld_resp_valid;
  logic [IW-1:0]   ld_resp_idx;
  logic [1:0]      ld_resp_code;
  logic [DW-1:0]   ld_resp_data;
  logic            cache_rd_valid;
  logic [AW-1:0]   cache_rd_addr;
  logic [IW-1:0]   cache_rd_tag;
  logic            cache_fill_valid = 0;
  logic [IW-1:0]   cache_fill_tag = '0;
  logic [DW-1:0]   cache_fill_data = '0;
  logic            retire_valid = 0;
  logic            cache_wr_valid;
  logic [AW-1:0]   cache_wr_addr;
  logic [DW-1:0]   cache_wr_data;
  logic            flush_valid = 0;
  logic [SEQW-1:0] flush_seq = '0;
  logic            head_valid, head_is_store, head_exec, head_done, head_fault;
  logic [SEQW-1:0] head_seq;
  logic [PCW-1:0]  head_pc;
  logic [DW-1:0]   head_value;

  ldst_queue dut_i (.*);

  int checks = 0;
  int errs = 0;
  logic [SEQW-1:0] seq_ctr = 8'd0;
  bit finished = 0;

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_alloc(input logic st, output logic [IW-1:0] idx);
    idx = alloc_idx;
    alloc_valid = 1; alloc_is_store = st; alloc_pc = PCW'(16'h4000) + PCW'(seq_ctr);
    alloc_seq = seq_ctr;
    tick();
    alloc_valid = 0;
    seq_ctr = seq_ctr + 1'b1;
  endtask

  task automatic do_upd(input logic [IW-1:0] idx, input logic av, input logic [AW-1:0] a,
                        input logic dv, input logic [DW-1:0] d, input logic f);
    upd_valid = 1; upd_idx = idx; upd_addr_valid = av; upd_addr = a;
    upd_data_valid = dv; upd_data = d; upd_fault = f;
    tick();
    upd_valid = 0; upd_addr_valid = 0; upd_data_valid = 0; upd_fault = 0;
  endtask

  task automatic do_flush(input logic [SEQW-1:0] s);
    flush_valid = 1; flush_seq = s;
    tick();
    flush_valid = 0;
  endtask

  task automatic do_retire();
    retire_valid = 1;
    tick();
    retire_valid = 0;
  endtask

  task automatic do_ldreq(input logic [IW-1:0] idx);
    ld_req_valid = 1; ld_req_idx = idx;
    tick();
    ld_req_valid = 0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errs++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin : main
    logic [IW-1:0] idx, li, yi;
    logic [IW-1:0] sidx [3];
    logic [SEQW-1:0] base;
    repeat (3) tick();
    rst = 0;
    tick();
    // R1 reset state
    chk("R1 head_valid", head_valid, 0);
    chk("R1 alloc_ready", alloc_ready, 1);
    chk("R1 ld_resp_valid", ld_resp_valid, 0);
    chk("R1 cache_rd_valid", cache_rd_valid, 0);
    chk("R1 cache_wr_valid", cache_wr_valid, 0);

    // R2 fill the queue with stores, then R9 in-order retire writes
    for (int i = 0; i < DEPTH; i++) begin
      chk("R2 alloc_idx order", alloc_idx, i);
      do_alloc(1'b1, idx);
      do_upd(idx, 1, AW'(16'h0010 + i), 1, DW'(16'h0100 + i), 0);
    end
    chk("R2 full alloc_ready", alloc_ready, 0);
    alloc_valid = 1; alloc_is_store = 0; alloc_seq = seq_ctr;
    tick();
    alloc_valid = 0;
    for (int i = 0; i < DEPTH; i++) begin
      chk("R9 head_seq order", head_seq, SEQW'(i));
      do_retire();
      chk("R9 cache_wr_valid", cache_wr_valid, 1);
      chk("R9 cache_wr_addr", cache_wr_addr, 16'h0010 + i);
      chk("R9 cache_wr_data", cache_wr_data, 16'h0100 + i);
    end
    chk("R2 ignored alloc when full", head_valid, 0);

    // R6/R8 cache path and fill, R9 load retire writes nothing
    do_alloc(1'b0, li);
    do_upd(li, 1, 16'h0777, 0, '0, 0);
    do_ldreq(li);
    chk("R6 code cache", ld_resp_code, 3);
    chk("R3 resp idx", ld_resp_idx, li);
    chk("R6 rd valid", cache_rd_valid, 1);
    chk("R6 rd addr", cache_rd_addr, 16'h0777);
    chk("R6 rd tag", cache_rd_tag, li);
    cache_fill_valid = 1; cache_fill_tag = li; cache_fill_data = 16'hBEEF;
    tick();
    cache_fill_valid = 0;
    chk("R8 head_done", head_done, 1);
    chk("R8 head_value", head_value, 16'hBEEF);
    chk("R8 head_exec", head_exec, 1);
    do_retire();
    chk("R9 load retire no write", cache_wr_valid, 0);

    // R11 fault flag
    base = seq_ctr;
    do_alloc(1'b1, idx);
    do_upd(idx, 0, '0, 0, '0, 1);
    chk("R11 head_fault", head_fault, 1);
    chk("R11 head_is_store", head_is_store, 1);
    do_flush(base - 1'b1);
    chk("R10 flush all", head_valid, 0);

    // R10 partial flush with a colliding allocation
    base = seq_ctr;
    for (int i = 0; i < 4; i++) do_alloc(1'b0, idx);
    flush_valid = 1; flush_seq = base + 1'b1;
    alloc_valid = 1; alloc_seq = seq_ctr; alloc_is_store = 1;
    tick();
    flush_valid = 0; alloc_valid = 0;
    chk("R10 tail after flush", alloc_idx, (head_seq == base) ? 3 : 0);
    chk("R10 kept oldest", head_seq, base);
    do_retire();
    chk("R10 kept second", head_seq, base + 1'b1);
    do_retire();
    chk("R10 younger removed", head_valid, 0);

    // Sweep: three older stores (addr unknown/match/differ, data known or not),
    // one load, one younger matching store with data.
    for (int c = 0; c < 27; c++) begin
      for (int dm = 0; dm < 8; dm++) begin
        int st [3];
        logic [AW-1:0] a_m, a_d;
        int exp_code, win;
        logic [DW-1:0] exp_data;
        st[0] = c % 3; st[1] = (c / 3) % 3; st[2] = c / 9;
        a_m = AW'(16'h0100 + c * 8 + dm);
        a_d = a_m ^ AW'(1);
        base = seq_ctr;
        for (int k = 0; k < 3; k++) do_alloc(1'b1, sidx[k]);
        do_alloc(1'b0, li);
        do_alloc(1'b1, yi);
        for (int k = 0; k < 3; k++)
          do_upd(sidx[k], st[k] != 0, (st[k] == 1) ? a_m : a_d, dm[k], DW'(16'h2000 + 16 * c + k), 0);
        do_upd(li, 1, a_m, 0, '0, 0);
        do_upd(yi, 1, a_m, 1, 16'hEEEE, 0);
        exp_code = 3; win = -1; exp_data = '0;
        for (int k = 0; k < 3; k++) if (st[k] == 1) win = k;
        if (st[0] == 0 || st[1] == 0 || st[2] == 0) exp_code = 0;
        else if (win >= 0) begin
          if (dm[win]) begin
            exp_code = 2;
            exp_data = DW'(16'h2000 + 16 * c + win);
          end else exp_code = 1;
        end
        do_ldreq(li);
        case (exp_code)
          0: chk("R3 wait-address code", ld_resp_code, 0);
          1: chk("R5 wait-data code", ld_resp_code, 1);
          2: begin
               chk("R4 forward code", ld_resp_code, 2);
               chk("R4 R7 forward data youngest older", ld_resp_data, exp_data);
             end
          default: begin
               chk("R6 R7 cache code", ld_resp_code, 3);
               chk("R6 cache addr", cache_rd_addr, a_m);
             end
        endcase
        chk("R5 R6 cache read only on miss", cache_rd_valid, exp_code == 3);
        do_flush(base - 1'b1);
        chk("R10 sweep flush empties", head_valid, 0);
      end
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule